// File: doc/BRIEF.md
# D-PHY Receiver Bring-up Sequencer

This block takes a D-PHY receiver from power-down to operational for a requested lane rate (in Mbps) and a requested number of active data lanes. A single start command runs a fixed series of phases. It records the lane configuration and holds the PHY in shutdown and reset. It pulses the PHY test-clear line. It then selects a 6-bit high-speed frequency-range code for the rate and writes it into the PHY through its byte-wide test port. Finally it releases shutdown, then reset, and then the host-side reset. Each phase is separated by a timed wait.

All waits are counted in clock cycles. The count is derived from a clock-cycles-per-microsecond parameter and a microsecond length for each phase. The ready flag rises once the final settle wait has run out. A stop command returns the lane configuration to a single lane and puts the host side back into reset. It leaves the PHY lines alone. A rate outside the supported band raises a sticky error flag. Bring-up still completes, using the nearest end of the range table.

Top module: `rxPhyBringup`

## Requirements
- R1: After reset, every output is 0: phyShutdownN, phyResetN, testClk, testEn, testClr, testDin, laneCfg, hostRelease, ready and rateErr.
- R2: On the cycle after a start command is accepted, phyShutdownN and phyResetN are 0 and laneCfg holds laneCount−1. A laneCount of 0 gives 0, and a laneCount above MAX_LANES gives MAX_LANES−1.
- R3: testClr is high for CLR_US×CYCLES_PER_US cycles while testClk is high and testEn is low. It then stays low for CLR_US×CYCLES_PER_US cycles, and the test-port write latches its address 4 cycles after that.
- R4: The range code is taken from the first entry of the package table (limits 89, 99, 109 … 1449, 1500 Mbps) whose limit is at least the rate. A rate above 1500 uses the last entry, 6'b111100. The code is sent as the data byte {1'b0, code[5:0], 1'b0}.
- R5: Each bring-up makes exactly one test-port write. The address 8'h44 is latched on a falling testClk while testEn is high. The data is latched 3 cycles later, on a rising testClk while testEn is low.
- R6: phyShutdownN rises PRE_US×CYCLES_PER_US cycles after the data latch. phyResetN rises PRE_US×CYCLES_PER_US cycles after that, and never while phyShutdownN is low.
- R7: hostRelease rises on the same cycle as phyResetN. ready rises SETTLE_US×CYCLES_PER_US cycles later, and while ready is high phyResetN, phyShutdownN and hostRelease are all high.
- R8: A rate below 80 or above 1500 sets rateErr, and the sequence still completes. rateErr stays set until reset.
- R9: A stop command clears ready, laneCfg and hostRelease on the next cycle and leaves phyShutdownN and phyResetN as they were. A stop issued mid-sequence abandons the sequence.
- R10: A start command during a sequence is ignored. A start command issued from idle or from ready begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | One-cycle request to begin bring-up |
| stopCmd | input | 1 | One-cycle request to stop; wins over startCmd |
| rateMbps | input | RATE_W (11) | Lane rate in Mbps, captured at start |
| laneCount | input | 3 | Number of active data lanes, captured at start |
| phyShutdownN | output | 1 | PHY shutdown control, low = shut down |
| phyResetN | output | 1 | PHY reset control, low = in reset |
| testClk | output | 1 | PHY test-port clock |
| testEn | output | 1 | PHY test-port enable, high = address phase |
| testClr | output | 1 | PHY test-port clear |
| testDin | output | 8 | PHY test-port data byte |
| laneCfg | output | 2 | Active lanes minus one |
| hostRelease | output | 1 | High = host side released from reset |
| ready | output | 1 | Bring-up complete |
| rateErr | output | 1 | Sticky out-of-range rate flag |

## Verification
The assertions assume that startCmd and stopCmd are one-cycle pulses driven synchronously. They also assume that rateMbps and laneCount are stable on the cycle start is sampled, because they are captured only then. The stimulus changes inputs only on the falling clock edge and keeps them steady across each start. It issues extra start pulses only at deliberate points in the middle of a sequence, and issues stop only after ready or during a timed wait. The sweep covers every table limit and the rate just above it. Lane counts cycle through every encodable value, including 0 and values above the maximum.

// File: rtl/rxBringupPkg.sv
`timescale 1ns/1ps
package rxBringupPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_CLR_HI, S_CLR_LO, S_XACT,
    S_PRE_SD, S_PRE_RST, S_SETTLE, S_READY
  } seqState_t;

  // One-cycle commands from the controller to the datapath registers
  typedef struct packed {
    logic loadCfg;
    logic stopCfg;
    logic phyHold;
    logic clrOn;
    logic clrOff;
    logic clkHi;
    logic clkLo;
    logic enHi;
    logic enLo;
    logic dinCode;
    logic dinData;
    logic sdRelease;
    logic rstRelease;
    logic hostOn;
  } seqStrobe_t;

  localparam int RANGE_ENTRIES = 39;
  localparam int RATE_MIN      = 80;
  localparam int RATE_MAX      = 1500;

  // Packed as {upper rate limit in Mbps [16:6], range code [5:0]}
  function automatic logic [16:0] rangeEntry(input int idx);
    case (idx)
      0:  rangeEntry = {11'd89,   6'b000000};
      1:  rangeEntry = {11'd99,   6'b010000};
      2:  rangeEntry = {11'd109,  6'b100000};
      3:  rangeEntry = {11'd129,  6'b000001};
      4:  rangeEntry = {11'd139,  6'b010001};
      5:  rangeEntry = {11'd149,  6'b100001};
      6:  rangeEntry = {11'd169,  6'b000010};
      7:  rangeEntry = {11'd179,  6'b010010};
      8:  rangeEntry = {11'd199,  6'b100010};
      9:  rangeEntry = {11'd219,  6'b000011};
      10: rangeEntry = {11'd239,  6'b010011};
      11: rangeEntry = {11'd249,  6'b100011};
      12: rangeEntry = {11'd269,  6'b000100};
      13: rangeEntry = {11'd299,  6'b010100};
      14: rangeEntry = {11'd329,  6'b000101};
      15: rangeEntry = {11'd359,  6'b010101};
      16: rangeEntry = {11'd399,  6'b100101};
      17: rangeEntry = {11'd449,  6'b000110};
      18: rangeEntry = {11'd499,  6'b010110};
      19: rangeEntry = {11'd549,  6'b000111};
      20: rangeEntry = {11'd599,  6'b010111};
      21: rangeEntry = {11'd649,  6'b001000};
      22: rangeEntry = {11'd699,  6'b011000};
      23: rangeEntry = {11'd749,  6'b001001};
      24: rangeEntry = {11'd799,  6'b011001};
      25: rangeEntry = {11'd849,  6'b101001};
      26: rangeEntry = {11'd899,  6'b111001};
      27: rangeEntry = {11'd949,  6'b001010};
      28: rangeEntry = {11'd999,  6'b011010};
      29: rangeEntry = {11'd1049, 6'b101010};
      30: rangeEntry = {11'd1099, 6'b111010};
      31: rangeEntry = {11'd1149, 6'b001011};
      32: rangeEntry = {11'd1199, 6'b011011};
      33: rangeEntry = {11'd1249, 6'b101011};
      34: rangeEntry = {11'd1299, 6'b111011};
      35: rangeEntry = {11'd1349, 6'b001100};
      36: rangeEntry = {11'd1399, 6'b011100};
      37: rangeEntry = {11'd1449, 6'b101100};
      default: rangeEntry = {11'd1500, 6'b111100};
    endcase
  endfunction

endpackage

// File: rtl/rxBringupCtrl.sv
`timescale 1ns/1ps
module rxBringupCtrl
  import rxBringupPkg::*;
#(
  parameter int CYCLES_PER_US = 200,
  parameter int CLR_US        = 15,
  parameter int PRE_US        = 5,
  parameter int SETTLE_US     = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       stopCmd,
  output seqStrobe_t strobe,
  output logic       ready
);

  localparam int CLR_CYC    = CLR_US * CYCLES_PER_US;
  localparam int PRE_CYC    = PRE_US * CYCLES_PER_US;
  localparam int SETTLE_CYC = SETTLE_US * CYCLES_PER_US;
  localparam int MAX_A      = (CLR_CYC > PRE_CYC) ? CLR_CYC : PRE_CYC;
  localparam int MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] CLR_LOAD    = TW'(CLR_CYC - 1);
  localparam logic [TW-1:0] PRE_LOAD    = TW'(PRE_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);

  seqState_t     state, nextState;
  logic [TW-1:0] timer, nextTimer;
  logic [2:0]    step, nextStep;
  logic          timerDone;

  assign timerDone = (timer == '0);
  assign ready     = (state == S_READY);

  always_comb begin
    nextState = state;
    nextStep  = step;
    nextTimer = timerDone ? timer : timer - 1'b1;
    strobe    = '0;
    case (state)
      S_IDLE, S_READY: if (startCmd) begin
        strobe.loadCfg = 1'b1;
        strobe.phyHold = 1'b1;
        nextState      = S_HOLD;
      end
      S_HOLD: begin
        strobe.clkHi = 1'b1;
        strobe.enLo  = 1'b1;
        strobe.clrOn = 1'b1;
        nextTimer    = CLR_LOAD;
        nextState    = S_CLR_HI;
      end
      S_CLR_HI: if (timerDone) begin
        strobe.clrOff = 1'b1;
        nextTimer     = CLR_LOAD;
        nextState     = S_CLR_LO;
      end
      S_CLR_LO: if (timerDone) begin
        nextStep  = '0;
        nextState = S_XACT;
      end
      S_XACT: begin
        nextStep = step + 1'b1;
        case (step)
          3'd0: begin strobe.clkHi = 1'b1; strobe.enLo = 1'b1; end
          3'd1: strobe.dinCode = 1'b1;
          3'd2: strobe.enHi    = 1'b1;
          3'd3: strobe.clkLo   = 1'b1;
          3'd4: strobe.enLo    = 1'b1;
          3'd5: strobe.dinData = 1'b1;
          default: begin
            strobe.clkHi = 1'b1;
            nextTimer    = PRE_LOAD;
            nextState    = S_PRE_SD;
          end
        endcase
      end
      S_PRE_SD: if (timerDone) begin
        strobe.sdRelease = 1'b1;
        nextTimer        = PRE_LOAD;
        nextState        = S_PRE_RST;
      end
      S_PRE_RST: if (timerDone) begin
        strobe.rstRelease = 1'b1;
        strobe.hostOn     = 1'b1;
        nextTimer         = SETTLE_LOAD;
        nextState         = S_SETTLE;
      end
      S_SETTLE: if (timerDone) nextState = S_READY;
      default: nextState = S_IDLE;
    endcase
    if (stopCmd) begin
      strobe         = '0;
      strobe.stopCfg = 1'b1;
      nextState      = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
      step  <= '0;
    end else begin
      state <= nextState;
      timer <= nextTimer;
      step  <= nextStep;
    end
  end

  // R10: a start arriving mid-sequence never restarts the hold phase
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!(state inside {S_IDLE, S_READY}) && startCmd) |=> (state != S_HOLD));

endmodule

// File: rtl/rxBringupDatapath.sv
`timescale 1ns/1ps
module rxBringupDatapath
  import rxBringupPkg::*;
#(
  parameter int          RATE_W    = 11,
  parameter int          MAX_LANES = 4,
  parameter int          LANE_IN_W = 3,
  parameter int          LANE_W    = 2,
  parameter logic [7:0]  TEST_ADDR = 8'h44
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [RATE_W-1:0]    rateIn,
  input  logic [LANE_IN_W-1:0] laneIn,
  output logic                 phyShutdownN,
  output logic                 phyResetN,
  output logic                 testClk,
  output logic                 testEn,
  output logic                 testClr,
  output logic [7:0]           testDin,
  output logic [LANE_W-1:0]    laneCfg,
  output logic                 hostRelease,
  output logic                 rateErr
);

  logic [5:0]        lutCode, codeReg;
  logic [16:0]       ent;
  logic [LANE_W-1:0] laneNext;
  logic              outOfRange;

  // Range search: scanning downward leaves the first limit >= rate
  always_comb begin
    lutCode = 6'b111100;
    ent     = '0;
    for (int i = RANGE_ENTRIES - 1; i >= 0; i--) begin
      ent = rangeEntry(i);
      if (32'(rateIn) <= 32'(ent[16:6])) lutCode = ent[5:0];
    end
  end

  assign outOfRange = (32'(rateIn) < RATE_MIN) || (32'(rateIn) > RATE_MAX);

  always_comb begin
    if (laneIn == '0)                  laneNext = '0;
    else if (32'(laneIn) > MAX_LANES)  laneNext = LANE_W'(MAX_LANES - 1);
    else                               laneNext = LANE_W'(laneIn - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneCfg     <= '0;
      hostRelease <= 1'b0;
      codeReg     <= '0;
      rateErr     <= 1'b0;
    end else begin
      if (strobe.loadCfg) begin
        laneCfg     <= laneNext;
        hostRelease <= 1'b0;
        codeReg     <= lutCode;
        if (outOfRange) rateErr <= 1'b1;
      end
      if (strobe.stopCfg) begin
        laneCfg     <= '0;
        hostRelease <= 1'b0;
      end
      if (strobe.hostOn) hostRelease <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyShutdownN <= 1'b0;
      phyResetN    <= 1'b0;
      testClk      <= 1'b0;
      testEn       <= 1'b0;
      testClr      <= 1'b0;
      testDin      <= '0;
    end else begin
      if (strobe.phyHold) begin
        phyShutdownN <= 1'b0;
        phyResetN    <= 1'b0;
      end
      if (strobe.sdRelease)  phyShutdownN <= 1'b1;
      if (strobe.rstRelease) phyResetN    <= 1'b1;
      if (strobe.clkHi)      testClk      <= 1'b1;
      if (strobe.clkLo)      testClk      <= 1'b0;
      if (strobe.enHi)       testEn       <= 1'b1;
      if (strobe.enLo)       testEn       <= 1'b0;
      if (strobe.clrOn)      testClr      <= 1'b1;
      if (strobe.clrOff)     testClr      <= 1'b0;
      if (strobe.dinCode)    testDin      <= TEST_ADDR;
      if (strobe.dinData)    testDin      <= {1'b0, codeReg, 1'b0};
    end
  end

  p_reset_after_shutdown_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyResetN) |-> phyShutdownN);

  p_clear_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    testClr |-> !testEn);

  p_clear_clock_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testClr) |-> testClk);

  p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    rateErr |=> rateErr);

endmodule

// File: rtl/rxPhyBringup.sv
`timescale 1ns/1ps
module rxPhyBringup
  import rxBringupPkg::*;
#(
  parameter int CYCLES_PER_US = 200,
  parameter int CLR_US        = 15,
  parameter int PRE_US        = 5,
  parameter int SETTLE_US     = 10,
  parameter int RATE_W        = 11,
  parameter int MAX_LANES     = 4,
  localparam int LANE_IN_W    = $clog2(MAX_LANES + 1),
  localparam int LANE_W       = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startCmd,
  input  logic                 stopCmd,
  input  logic [RATE_W-1:0]    rateMbps,
  input  logic [LANE_IN_W-1:0] laneCount,
  output logic                 phyShutdownN,
  output logic                 phyResetN,
  output logic                 testClk,
  output logic                 testEn,
  output logic                 testClr,
  output logic [7:0]           testDin,
  output logic [LANE_W-1:0]    laneCfg,
  output logic                 hostRelease,
  output logic                 ready,
  output logic                 rateErr
);

  seqStrobe_t strobe;

  rxBringupCtrl #(
    .CYCLES_PER_US(CYCLES_PER_US), .CLR_US(CLR_US),
    .PRE_US(PRE_US), .SETTLE_US(SETTLE_US)
  ) ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .strobe(strobe), .ready(ready)
  );

  rxBringupDatapath #(
    .RATE_W(RATE_W), .MAX_LANES(MAX_LANES),
    .LANE_IN_W(LANE_IN_W), .LANE_W(LANE_W), .TEST_ADDR(8'h44)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rateIn(rateMbps), .laneIn(laneCount),
    .phyShutdownN(phyShutdownN), .phyResetN(phyResetN), .testClk(testClk),
    .testEn(testEn), .testClr(testClr), .testDin(testDin), .laneCfg(laneCfg),
    .hostRelease(hostRelease), .rateErr(rateErr)
  );

  p_ready_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (phyResetN && phyShutdownN && hostRelease));

  p_stop_effect_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (!ready && laneCfg == '0 && !hostRelease));

endmodule

// File: tb/rxPhyBringup_test.sv
`timescale 1ns/1ps
module rxPhyBringup_test;

  localparam int CPU   = 2;
  localparam int N_CLR = 15 * CPU;
  localparam int N_PRE = 5 * CPU;
  localparam int N_SET = 10 * CPU;

  logic clk = 1'b0, rstN = 1'b0, startCmd = 1'b0, stopCmd = 1'b0;
  logic [10:0] rateMbps = '0;
  logic [2:0]  laneCount = '0;
  logic phyShutdownN, phyResetN, testClk, testEn, testClr, hostRelease, ready, rateErr;
  logic [7:0] testDin;
  logic [1:0] laneCfg;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;

  rxPhyBringup #(.CYCLES_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .rateMbps(rateMbps), .laneCount(laneCount),
    .phyShutdownN(phyShutdownN), .phyResetN(phyResetN), .testClk(testClk),
    .testEn(testEn), .testClr(testClr), .testDin(testDin), .laneCfg(laneCfg),
    .hostRelease(hostRelease), .ready(ready), .rateErr(rateErr)
  );

  always #2.5 clk = ~clk;

  // Expected table: limit*64 + code
  function automatic int tbl(input int i);
    case (i)
      0: tbl = 89*64+6'b000000;    1: tbl = 99*64+6'b010000;    2: tbl = 109*64+6'b100000;
      3: tbl = 129*64+6'b000001;   4: tbl = 139*64+6'b010001;   5: tbl = 149*64+6'b100001;
      6: tbl = 169*64+6'b000010;   7: tbl = 179*64+6'b010010;   8: tbl = 199*64+6'b100010;
      9: tbl = 219*64+6'b000011;   10: tbl = 239*64+6'b010011;  11: tbl = 249*64+6'b100011;
      12: tbl = 269*64+6'b000100;  13: tbl = 299*64+6'b010100;  14: tbl = 329*64+6'b000101;
      15: tbl = 359*64+6'b010101;  16: tbl = 399*64+6'b100101;  17: tbl = 449*64+6'b000110;
      18: tbl = 499*64+6'b010110;  19: tbl = 549*64+6'b000111;  20: tbl = 599*64+6'b010111;
      21: tbl = 649*64+6'b001000;  22: tbl = 699*64+6'b011000;  23: tbl = 749*64+6'b001001;
      24: tbl = 799*64+6'b011001;  25: tbl = 849*64+6'b101001;  26: tbl = 899*64+6'b111001;
      27: tbl = 949*64+6'b001010;  28: tbl = 999*64+6'b011010;  29: tbl = 1049*64+6'b101010;
      30: tbl = 1099*64+6'b111010; 31: tbl = 1149*64+6'b001011; 32: tbl = 1199*64+6'b011011;
      33: tbl = 1249*64+6'b101011; 34: tbl = 1299*64+6'b111011; 35: tbl = 1349*64+6'b001100;
      36: tbl = 1399*64+6'b011100; 37: tbl = 1449*64+6'b101100; default: tbl = 1500*64+6'b111100;
    endcase
  endfunction

  function automatic int expCode(input int rate);
    for (int i = 0; i < 39; i++) if (rate <= tbl(i) / 64) return tbl(i) % 64;
    return tbl(38) % 64;
  endfunction

  function automatic int expLane(input int n);
    if (n == 0) return 0;
    if (n > 4) return 3;
    return n - 1;
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Event recorder, sampled on the falling edge
  int clrRiseCnt, clrRise, clrFall, codeCnt, codeVal, codeCyc, dataCnt, dataVal, dataCyc;
  int sdRise, rstRise, hostRise, readyRise;
  logic pClk = 0, pClr = 0, pSd = 0, pRst = 0, pHost = 0, pReady = 0;

  task automatic clearRec();
    clrRiseCnt = 0; codeCnt = 0; dataCnt = 0;
    clrRise = -1; clrFall = -1; codeCyc = -1; dataCyc = -1; codeVal = -1; dataVal = -1;
    sdRise = -1; rstRise = -1; hostRise = -1; readyRise = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (testClr && !pClr) begin clrRiseCnt++; clrRise = cyc; end
    if (!testClr && pClr) clrFall = cyc;
    if (pClk && !testClk && testEn) begin codeCnt++; codeVal = int'(testDin); codeCyc = cyc; end
    if (!pClk && testClk && !testEn && codeCnt > 0) begin dataCnt++; dataVal = int'(testDin); dataCyc = cyc; end
    if (phyShutdownN && !pSd) sdRise = cyc;
    if (phyResetN && !pRst) rstRise = cyc;
    if (hostRelease && !pHost) hostRise = cyc;
    if (ready && !pReady) readyRise = cyc;
    pClk = testClk; pClr = testClr; pSd = phyShutdownN; pRst = phyResetN;
    pHost = hostRelease; pReady = ready;
  end

  task automatic runBringup(input int rate, input int lanes, input bit poke, input int expErr);
    bit poked = 0;
    @(negedge clk);
    clearRec();
    rateMbps = 11'(rate); laneCount = 3'(lanes); startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    checkEq("R2 laneCfg", int'(laneCfg), expLane(lanes));
    checkEq("R2 PHY held", int'({phyShutdownN, phyResetN}), 0);
    for (int k = 0; k < 400 && !ready; k++) begin
      @(negedge clk);
      if (poke && !poked && clrFall >= 0 && cyc >= clrFall + 3) begin
        startCmd = 1'b1; poked = 1;
      end else startCmd = 1'b0;
    end
    startCmd = 1'b0;
    @(negedge clk);
    checkEq(poke ? "R10 single clear pulse" : "R3 single clear pulse", clrRiseCnt, 1);
    checkEq("R3 clear high width", clrFall - clrRise, N_CLR);
    checkEq("R3 clear low to address latch", codeCyc - clrFall, N_CLR + 4);
    checkEq("R5 address count", codeCnt, 1);
    checkEq("R5 address value", codeVal, 'h44);
    checkEq("R5 data count", dataCnt, 1);
    checkEq("R5 data 3 cycles after address", dataCyc - codeCyc, 3);
    checkEq("R4 range data byte", dataVal, expCode(rate) * 2);
    checkEq("R6 shutdown release delay", sdRise - dataCyc, N_PRE);
    checkEq("R6 reset release delay", rstRise - sdRise, N_PRE);
    checkEq("R7 host with reset", hostRise, rstRise);
    checkEq("R7 settle to ready", readyRise - rstRise, N_SET);
    checkEq("R8 rateErr", int'(rateErr), expErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clearRec();
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 reset outputs",
      int'({phyShutdownN, phyResetN, testClk, testEn, testClr, testDin, laneCfg,
            hostRelease, ready, rateErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 idle ready", int'(ready), 0);

    // R4 sweep over every limit and the rate just above it
    for (int i = 0; i < 39; i++) begin
      runBringup(tbl(i) / 64, i % 8, (i % 5) == 0, 0);
      if (i < 38) runBringup(tbl(i) / 64 + 1, (i + 3) % 8, 1'b0, 0);
    end
    runBringup(80, 4, 1'b0, 0);

    // R9 stop from ready
    @(negedge clk); stopCmd = 1'b1;
    @(negedge clk); stopCmd = 1'b0;
    checkEq("R9 stop clears ready", int'(ready), 0);
    checkEq("R9 stop clears laneCfg", int'(laneCfg), 0);
    checkEq("R9 stop clears hostRelease", int'(hostRelease), 0);
    checkEq("R9 stop keeps PHY released", int'({phyShutdownN, phyResetN}), 3);

    // R9 stop mid-sequence, then R10 restart from idle
    @(negedge clk); rateMbps = 11'd500; laneCount = 3'd2; startCmd = 1'b1;
    @(negedge clk); startCmd = 1'b0;
    repeat (40) @(negedge clk);
    stopCmd = 1'b1;
    @(negedge clk); stopCmd = 1'b0;
    repeat (150) @(negedge clk);
    checkEq("R9 abandoned sequence not ready", int'(ready), 0);
    checkEq("R9 abandoned sequence keeps shutdown", int'(phyShutdownN), 0);
    checkEq("R9 abandoned sequence laneCfg", int'(laneCfg), 0);
    runBringup(500, 2, 1'b0, 0);

    // R8 out-of-range rates, clamped entries, sticky flag
    runBringup(79, 1, 1'b0, 1);
    runBringup(0, 3, 1'b0, 1);
    runBringup(2000, 4, 1'b0, 1);
    runBringup(700, 4, 1'b0, 1);

    rstN = 1'b0;
    @(negedge clk);
    checkEq("R1 R8 reset clears rateErr", int'(rateErr), 0);
    rstN = 1'b1;
    runBringup(1500, 1, 1'b0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule